// File: doc/BRIEF.md
# Block Write-Protect Arbiter

This block decides whether a program or erase request to a byte address may reach the memory array. The array is split into equal blocks, 64 KByte by default, and the top-most block is the boot block. Each block has one software lock bit, kept in a small register file that is written and read by block number. Two active-low hardware pins add protection on top of the lock bits. The boot pin covers only the boot block. The array pin covers every other block. Each pin is ORed with the lock bit of the block it covers.

Requests arrive on a valid/ready stream. The arbiter takes one request at a time. `req_ready_o` is high only while the arbiter is idle, and a request is accepted on a rising edge where both valid and ready are high. The pin levels are captured at that same edge, so later pin changes cannot alter that operation. One cycle after acceptance the arbiter gives its verdict as a one-cycle pulse: `grant_o` or `reject_o`. After a grant, ready stays low until the array reports completion on `op_done_i`. After a reject, the request is dropped and ready returns on the next cycle. The register read-back always shows the stored lock bit, never the combined protection.

Top module: `blk_wprot_arbiter`

## Requirements
- R1: After reset every lock bit reads 1 (locked), `req_ready_o` is 1, and both `grant_o` and `reject_o` are 0.
- R2: A register write with `cfg_wr_i` high stores `cfg_wdata_i` into the lock bit of block `cfg_idx_i` on that clock edge. `cfg_rdata_o` shows, without delay, the stored bit of block `cfg_rd_idx_i` (1 = locked, 0 = unlocked).
- R3: The boot block is the block whose number is all ones (address bits above the block offset all 1). A request to it that is accepted while `tbl_n_i` is 0 is rejected, whatever its lock bit holds.
- R4: A boot block request accepted while `tbl_n_i` is 1 is granted when the boot lock bit is 0 and rejected when it is 1.
- R5: A request to any other block that is accepted while `wp_n_i` is 0 is rejected. A request accepted while `wp_n_i` is 1 follows that block's lock bit.
- R6: `wp_n_i` has no effect on boot block requests, and `tbl_n_i` has no effect on requests to other blocks.
- R7: Writing 0 to a lock bit while the matching pin is low stores the 0, and it reads back as 0. Requests to that block are still rejected while the pin stays low.
- R8: Both pins are sampled on the edge that accepts a request. Pin changes after that edge do not change the verdict for that request.
- R9: In the cycle after acceptance exactly one of `grant_o` or `reject_o` is high, for one cycle only. During a grant, `op_addr_o` carries the accepted address.
- R10: After a grant, `req_ready_o` stays 0 until a cycle in which `op_done_i` is 1, and it is 1 again in the cycle after that. After a reject, `req_ready_o` is 1 in the next cycle.
- R11: A lock write in the verdict cycle does not change that verdict. It takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_n_i | input | 1 | Boot block lock pin, active low |
| wp_n_i | input | 1 | Lock pin for all other blocks, active low |
| req_valid_i | input | 1 | Program/erase request valid |
| req_ready_o | output | 1 | Arbiter can accept a request |
| req_addr_i | input | ADDR_W | Byte address of the request |
| grant_o | output | 1 | One-cycle pulse: request may proceed |
| reject_o | output | 1 | One-cycle pulse: request dropped |
| op_addr_o | output | ADDR_W | Accepted address, valid with `grant_o` |
| op_done_i | input | 1 | Array reports the granted operation finished |
| cfg_wr_i | input | 1 | Lock register write strobe |
| cfg_idx_i | input | ADDR_W-BLK_W | Block number to write |
| cfg_wdata_i | input | 1 | Lock value to write (1 = locked) |
| cfg_rd_idx_i | input | ADDR_W-BLK_W | Block number to read |
| cfg_rdata_o | output | 1 | Stored lock bit of the read block |

## Verification
The verdict for a request and a software write to the same block's lock bit can fall in the same cycle. The bench provokes this in two ways. It issues lock writes during the verdict cycle in directed runs. It also issues them at random in the randomized loop. The verdict is judged against the lock value held before that write, and the following request must see the new value. Pin flips right after acceptance meet the verdict in the same way, and the verdict must follow the levels captured at acceptance.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_JUDGE = 2'd1,
    ST_BUSY  = 2'd2
  } wpa_state_e;
endpackage

// File: rtl/wpa_lock_regs.sv
module wpa_lock_regs #(
  parameter int IDX_W   = 4,
  parameter int NUM_BLK = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_bit,
  output logic [NUM_BLK-1:0] lock_vec
);
  logic [NUM_BLK-1:0] lock_q;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n)
        lock_q[g] <= 1'b1;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        lock_q[g] <= wr_bit;
    end
  end

  assign lock_vec = lock_q;

  // R2
  lock_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lock_q[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/wpa_judge.sv
module wpa_judge #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             tbl_n_i,
  input  logic             wp_n_i,
  input  logic [IDX_W-1:0] blk_idx,
  input  logic             lock_bit,
  output logic             deny
);
  logic tbl_n_q, wp_n_q;
  logic is_boot;

  // pins are held from acceptance to the end of the operation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_n_q <= 1'b0;
      wp_n_q  <= 1'b0;
    end else if (capture) begin
      tbl_n_q <= tbl_n_i;
      wp_n_q  <= wp_n_i;
    end
  end

  assign is_boot = &blk_idx;

  always_comb begin
    if (is_boot) deny = !tbl_n_q || lock_bit;
    else         deny = !wp_n_q  || lock_bit;
  end
endmodule

// File: rtl/blk_wprot_arbiter.sv
module blk_wprot_arbiter
  import wpa_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_n_i,
  input  logic                    wp_n_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_addr_i,
  output logic                    grant_o,
  output logic                    reject_o,
  output logic [ADDR_W-1:0]       op_addr_o,
  input  logic                    op_done_i,
  input  logic                    cfg_wr_i,
  input  logic [ADDR_W-BLK_W-1:0] cfg_idx_i,
  input  logic                    cfg_wdata_i,
  input  logic [ADDR_W-BLK_W-1:0] cfg_rd_idx_i,
  output logic                    cfg_rdata_o
);
  localparam int IDX_W   = ADDR_W - BLK_W;
  localparam int NUM_BLK = 1 << IDX_W;

  wpa_state_e         st_q, st_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [NUM_BLK-1:0] lock_vec;
  logic [IDX_W-1:0]   cur_idx;
  logic               accept, deny;

  assign accept  = req_valid_i && (st_q == ST_IDLE);
  assign cur_idx = addr_q[ADDR_W-1:BLK_W];

  wpa_lock_regs #(.IDX_W(IDX_W), .NUM_BLK(NUM_BLK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_i),
    .wr_idx   (cfg_idx_i),
    .wr_bit   (cfg_wdata_i),
    .lock_vec (lock_vec)
  );

  wpa_judge #(.IDX_W(IDX_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .tbl_n_i  (tbl_n_i),
    .wp_n_i   (wp_n_i),
    .blk_idx  (cur_idx),
    .lock_bit (lock_vec[cur_idx]),
    .deny     (deny)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_JUDGE;
      ST_JUDGE: st_d = deny ? ST_IDLE : ST_BUSY;
      ST_BUSY:  if (op_done_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) addr_q <= req_addr_i;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign grant_o     = (st_q == ST_JUDGE) && !deny;
  assign reject_o    = (st_q == ST_JUDGE) && deny;
  assign op_addr_o   = addr_q;
  assign cfg_rdata_o = lock_vec[cfg_rd_idx_i];

  // R9
  verdict_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o || reject_o) |-> $past(req_valid_i && req_ready_o));
  // R3
  boot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && (&op_addr_o[ADDR_W-1:BLK_W])) |-> $past(tbl_n_i));
  // R5
  array_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !(&op_addr_o[ADDR_W-1:BLK_W])) |-> $past(wp_n_i));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !req_ready_o);
  // R10
  reject_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> req_ready_o);
endmodule

// File: tb/blk_wprot_arbiter_bench.sv
module blk_wprot_arbiter_bench;
  localparam int ADDR_W = 20;
  localparam int BLK_W  = 16;
  localparam int IDX_W  = ADDR_W - BLK_W;
  localparam int NBLK   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_n = 1'b1, wp_n = 1'b1;
  logic req_valid = 1'b0, op_done = 1'b0, cfg_wr = 1'b0, cfg_wdata = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [IDX_W-1:0]  cfg_idx = '0, cfg_rd_idx = '0;
  logic req_ready, grant, reject, cfg_rdata;
  logic [ADDR_W-1:0] op_addr;

  int n_chk = 0, n_err = 0;
  logic lock_m [NBLK];
  bit done = 1'b0;

  always #4 clk = ~clk;

  blk_wprot_arbiter #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_blk_wprot_arbiter (
    .clk(clk), .rst_n(rst_n), .tbl_n_i(tbl_n), .wp_n_i(wp_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .grant_o(grant), .reject_o(reject), .op_addr_o(op_addr), .op_done_i(op_done),
    .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_rd_idx_i(cfg_rd_idx), .cfg_rdata_o(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_deny(input logic [IDX_W-1:0] idx, input logic tb, input logic wp, input logic lk);
    if (idx == IDX_W'(NBLK - 1)) return !tb || lk;
    return !wp || lk;
  endfunction

  task automatic cfg_write(input logic [IDX_W-1:0] idx, input logic val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
    lock_m[idx] = val;
    cfg_rd_idx = idx;
    #1;
    chk(cfg_rdata == val, "R2 readback", 32'(cfg_rdata), 32'(val));
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] addr, input logic tb, input logic wp,
                         input bit flip, input bit wr_mid, input logic [IDX_W-1:0] widx,
                         input logic wbit, input string tag);
    logic [IDX_W-1:0] idx;
    bit dn;
    idx = addr[ADDR_W-1:BLK_W];
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = addr; tbl_n = tb; wp_n = wp;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin tbl_n = ~tb; wp_n = ~wp; end
    dn = exp_deny(idx, tb, wp, lock_m[idx]);
    chk(grant == !dn && reject == dn, tag, {30'd0, grant, reject}, {30'd0, !dn, dn});
    if (!dn) chk(op_addr == addr, "R9 op address", 32'(op_addr), 32'(addr));
    if (wr_mid) begin cfg_wr = 1'b1; cfg_idx = widx; cfg_wdata = wbit; end
    @(negedge clk);
    if (wr_mid) begin cfg_wr = 1'b0; lock_m[widx] = wbit; end
    chk(!grant && !reject, "R9 single pulse", {30'd0, grant, reject}, 0);
    if (dn) begin
      chk(req_ready == 1'b1, "R10 ready after reject", 32'(req_ready), 1);
    end else begin
      chk(req_ready == 1'b0, "R10 busy after grant", 32'(req_ready), 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R10 busy hold", 32'(req_ready), 0);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      chk(req_ready == 1'b1, "R10 ready after done", 32'(req_ready), 1);
    end
  endtask

  function automatic logic [ADDR_W-1:0] blk_addr(input int b, input logic [BLK_W-1:0] off);
    return {IDX_W'(b), off};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NBLK; i++) lock_m[i] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !grant && !reject, "R1 outputs", {29'd0, req_ready, grant, reject}, 4);
    for (int i = 0; i < NBLK; i++) begin
      cfg_rd_idx = IDX_W'(i);
      #1;
      chk(cfg_rdata == 1'b1, "R1 lock reset", 32'(cfg_rdata), 1);
    end
    // R7 + R3: clear boot lock with boot pin low
    tbl_n = 1'b0;
    cfg_write(IDX_W'(NBLK - 1), 1'b0);
    run_req(blk_addr(NBLK - 1, 16'h0123), 1'b0, 1'b1, 0, 0, '0, 0, "R7 R3 boot pin blocks cleared lock");
    // R4
    run_req(blk_addr(NBLK - 1, 16'hFFFF), 1'b1, 1'b1, 0, 0, '0, 0, "R4 boot unlocked grant");
    cfg_write(IDX_W'(NBLK - 1), 1'b1);
    run_req(blk_addr(NBLK - 1, 16'h0000), 1'b1, 1'b1, 0, 0, '0, 0, "R4 boot locked reject");
    cfg_write(IDX_W'(NBLK - 1), 1'b0);
    // R5 + R7
    cfg_write(3, 1'b0);
    run_req(blk_addr(3, 16'h4000), 1'b1, 1'b0, 0, 0, '0, 0, "R5 R7 array pin blocks");
    run_req(blk_addr(3, 16'h4001), 1'b1, 1'b1, 0, 0, '0, 0, "R5 array unlocked grant");
    run_req(blk_addr(2, 16'h0010), 1'b1, 1'b1, 0, 0, '0, 0, "R5 array locked reject");
    // R6 independence
    run_req(blk_addr(NBLK - 1, 16'h0200), 1'b1, 1'b0, 0, 0, '0, 0, "R6 wp pin ignored for boot");
    run_req(blk_addr(3, 16'h0300), 1'b0, 1'b1, 0, 0, '0, 0, "R6 tbl pin ignored for array");
    // R8 pins flip after acceptance
    run_req(blk_addr(3, 16'h0400), 1'b1, 1'b1, 1, 0, '0, 0, "R8 flip after accept grant");
    run_req(blk_addr(NBLK - 1, 16'h0500), 1'b0, 1'b0, 1, 0, '0, 0, "R8 flip after accept reject");
    // R11 lock write in the verdict cycle
    run_req(blk_addr(3, 16'h0600), 1'b1, 1'b1, 0, 1, 3, 1'b1, "R11 verdict uses old lock");
    run_req(blk_addr(3, 16'h0601), 1'b1, 1'b1, 0, 0, '0, 0, "R11 next request sees new lock");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);
      if (($urandom % 4) == 0) cfg_write(IDX_W'($urandom), 1'($urandom));
      run_req(a, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0), bit'($urandom % 3 == 0),
              bit'($urandom % 5 == 0), IDX_W'($urandom), 1'($urandom), "R3 R4 R5 R11 random verdict");
    end
    finish_run();
  end
endmodule